// File: doc/BRIEF.md
# Conditional byte-order swap unit

This unit executes the byte-order conversion instruction of a 64-bit ALU. It takes the destination operand and the instruction's class bit, which picks the 32-bit class or the 64-bit class. It also takes the one-bit order field of the opcode and the immediate, which gives the conversion width. One clock after a valid request it returns the converted value and an illegal flag. The instruction has no source operand. Register writeback and the decode of the other fields are done elsewhere. The unit is reached only when the operation code is the byte-order code, 0xd0.

In the 32-bit class, the order field names a target byte order. Order value 0 selects little endian and order value 1 (opcode bit 0x08) selects big endian. Bytes are reversed only when the target differs from the host order. The host order is fixed by the parameter `HOST_BIG_ENDIAN`. In the 64-bit class the order field is reserved, and the bytes are always reversed. In every case, any bytes above the selected width are cleared in the result.

Top module: `bswap_unit`

## Requirements
- R1: While rst_ni is low and after its release, valid_o, result_o and illegal_o are all zero until the first accepted request.
- R2: valid_o equals valid_i delayed by exactly one clock. A request presented on a rising edge with valid_i high produces its result on result_o and illegal_o from that edge on.
- R3: In the 32-bit class (wide_class_i = 0), when the order field matches the host order, the low W bits of the operand pass unchanged. Here W is the width from the immediate. The order field matches when order_i = 0 on a little-endian host or order_i = 1 on a big-endian host. Bits W and above are zero.
- R4: In the 32-bit class, when the order field differs from the host order, the W/8 low bytes are reversed. The byte at position i moves to position W/8-1-i, and bits W and above are zero.
- R5: In the 64-bit class (wide_class_i = 1) with order_i = 0, the low W/8 bytes are always reversed, whatever the host order. Bits W and above are zero.
- R6: Only the immediate values 16, 32 and 64 are legal. Any other value sets illegal_o to 1 and returns the operand unchanged.
- R7: In the 64-bit class with order_i = 1, illegal_o is 1 and the operand is returned unchanged.
- R8: With width 64 and no reversal, the result equals the full operand and illegal_o is 0.
- R9: With HOST_BIG_ENDIAN = 1, the order value that causes a reversal in the 32-bit class is 0 rather than 1.
- R10: While valid_i is low, result_o and illegal_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| wide_class_i | input | 1 | 0 = 32-bit class, 1 = 64-bit class |
| order_i | input | 1 | Order field: 0 = little endian, 1 = big endian (reserved in 64-bit class) |
| width_i | input | 32 | Immediate giving the conversion width in bits |
| operand_i | input | 64 | Destination operand |
| valid_o | output | 1 | Result strobe, one clock after valid_i |
| result_o | output | 64 | Converted value |
| illegal_o | output | 1 | Encoding not allowed; result_o holds the operand |

## Verification
An illegal width and a reserved order bit can both be present in one request, and so can an illegal encoding and a conversion that would otherwise reverse bytes. The bench sends such combined encodings. Examples are the 64-bit class with order 1 and width 64, and the 64-bit class with order 1 and width 24. It expects the illegal path to win, with the operand returned untouched. A second instance built for a big-endian host receives every request, so the effect of the order bit and the host parameter is judged for both hosts in the same cycle.

// File: rtl/bswap_pkg.sv
package bswap_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MIN_W  = 16;

  typedef struct packed {
    logic illegal;
    logic swap;
  } bswap_ctl_t;
endpackage

// File: rtl/bswap_width_dec.sv
module bswap_width_dec #(
  parameter int unsigned IMM_W = 32,
  parameter int unsigned NUM_W = 3,
  localparam int unsigned SEL_W = (NUM_W > 1) ? $clog2(NUM_W) : 1
) (
  input  logic [IMM_W-1:0] width_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             legal_o
);
  always_comb begin
    sel_o   = '0;
    legal_o = 1'b0;
    for (int k = 0; k < NUM_W; k++) begin
      if (width_i == IMM_W'(bswap_pkg::MIN_W << k)) begin
        sel_o   = SEL_W'(k);
        legal_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (legal_o) begin
      p_sel_range_r6: assert (int'(sel_o) < NUM_W);
    end
  end
endmodule

// File: rtl/bswap_lane_mux.sv
module bswap_lane_mux #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NUM_W  = 3,
  localparam int unsigned SEL_W = (NUM_W > 1) ? $clog2(NUM_W) : 1
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              swap_i,
  output logic [DATA_W-1:0] result_o
);
  import bswap_pkg::*;

  logic [DATA_W-1:0] plain_c [NUM_W];
  logic [DATA_W-1:0] swap_c  [NUM_W];

  for (genvar k = 0; k < NUM_W; k++) begin : g_width
    localparam int unsigned NB = (MIN_W / BYTE_W) << k;
    for (genvar b = 0; b < NUM_W * 0 + DATA_W / BYTE_W; b++) begin : g_byte
      if (b < NB) begin : g_in
        assign plain_c[k][b*BYTE_W +: BYTE_W] = operand_i[b*BYTE_W +: BYTE_W];
        assign swap_c[k][b*BYTE_W +: BYTE_W]  = operand_i[(NB-1-b)*BYTE_W +: BYTE_W];
      end else begin : g_zero
        assign plain_c[k][b*BYTE_W +: BYTE_W] = '0;
        assign swap_c[k][b*BYTE_W +: BYTE_W]  = '0;
      end
    end
  end

  always_comb begin
    result_o = '0;
    for (int k = 0; k < NUM_W; k++) begin
      if (sel_i == SEL_W'(k)) result_o = swap_i ? swap_c[k] : plain_c[k];
    end
  end
endmodule

// File: rtl/bswap_unit.sv
module bswap_unit #(
  parameter int unsigned DATA_W          = 64,
  parameter int unsigned IMM_W           = 32,
  parameter bit          HOST_BIG_ENDIAN = 1'b0,
  localparam int unsigned NUM_W = $clog2(DATA_W / bswap_pkg::MIN_W) + 1,
  localparam int unsigned SEL_W = (NUM_W > 1) ? $clog2(NUM_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              wide_class_i,
  input  logic              order_i,
  input  logic [IMM_W-1:0]  width_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  import bswap_pkg::*;

  logic [SEL_W-1:0]  sel;
  logic              legal;
  logic [DATA_W-1:0] lane_res;
  bswap_ctl_t        ctl;

  bswap_width_dec #(.IMM_W(IMM_W), .NUM_W(NUM_W)) u_dec (
    .width_i (width_i),
    .sel_o   (sel),
    .legal_o (legal)
  );

  // 64-bit class always reverses; 32-bit class reverses when target != host
  always_comb begin
    ctl.illegal = !legal || (wide_class_i && order_i);
    ctl.swap    = wide_class_i || (order_i != HOST_BIG_ENDIAN);
  end

  bswap_lane_mux #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_lane (
    .operand_i (operand_i),
    .sel_i     (sel),
    .swap_i    (ctl.swap),
    .result_o  (lane_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= ctl.illegal ? operand_i : lane_res;
        illegal_o <= ctl.illegal;
      end
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(illegal_o)));
  p_reserved_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wide_class_i && order_i) |=> (illegal_o && result_o == $past(operand_i)));
  p_zero_ext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_class_i && width_i == IMM_W'(MIN_W))
      |=> (illegal_o || result_o[DATA_W-1:MIN_W] == '0));
  p_bad_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && width_i != IMM_W'(16) && width_i != IMM_W'(32) && width_i != IMM_W'(64))
      |=> illegal_o);
endmodule

// File: tb/bswap_unit_tb.sv
module bswap_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        wide = 1'b0;
  logic        order = 1'b0;
  logic [31:0] width = 32'd16;
  logic [63:0] op = '0;
  logic        v_le, v_be, ill_le, ill_be;
  logic [63:0] r_le, r_be;
  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bswap_unit #(.HOST_BIG_ENDIAN(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .wide_class_i(wide),
    .order_i(order), .width_i(width), .operand_i(op),
    .valid_o(v_le), .result_o(r_le), .illegal_o(ill_le));

  bswap_unit #(.HOST_BIG_ENDIAN(1'b1)) u_dut_be (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .wide_class_i(wide),
    .order_i(order), .width_i(width), .operand_i(op),
    .valid_o(v_be), .result_o(r_be), .illegal_o(ill_be));

  // behavioural reference: returns {illegal, result}
  function automatic logic [64:0] model(bit big_host, bit w, bit o,
                                        logic [31:0] wd, logic [63:0] d);
    logic [63:0] r = '0;
    int nb;
    bit rev;
    if (!(wd == 16 || wd == 32 || wd == 64) || (w && o)) return {1'b1, d};
    nb  = int'(wd) / 8;
    rev = w ? 1'b1 : (big_host ? (o == 1'b0) : (o == 1'b1));
    for (int i = 0; i < nb; i++) begin
      if (rev) r[i*8 +: 8] = d[(nb-1-i)*8 +: 8];
      else     r[i*8 +: 8] = d[i*8 +: 8];
    end
    return {1'b0, r};
  endfunction

  task automatic check(string req, logic [64:0] act, logic [64:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual ill=%0b res=%h expected ill=%0b res=%h",
               req, act[64], act[63:0], exp[64], exp[63:0]);
    end
  endtask

  task automatic run(string req, bit w, bit o, logic [31:0] wd, logic [63:0] d);
    logic [64:0] e_le, e_be;
    @(negedge clk);
    valid = 1'b1; wide = w; order = o; width = wd; op = d;
    e_le = model(1'b0, w, o, wd, d);
    e_be = model(1'b1, w, o, wd, d);
    @(posedge clk); #1;
    check({req, " R2 valid"}, {64'd0, v_le & v_be}, 65'd1);
    check({req, " le-host"}, {ill_le, r_le}, e_le);
    check({req, " be-host R9"}, {ill_be, r_be}, e_be);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [64:0] held;
    #23;
    check("R1 reset", {ill_le, r_le}, 65'd0);
    check("R1 reset valid", {64'd0, v_le}, 65'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {v_le, r_le}, 65'd0);

    run("R3 le 16", 1'b0, 1'b0, 32'd16, 64'h1122334455667788);
    run("R3 le 32", 1'b0, 1'b0, 32'd32, 64'h1122334455667788);
    run("R8 le 64", 1'b0, 1'b0, 32'd64, 64'h1122334455667788);
    run("R4 be 16", 1'b0, 1'b1, 32'd16, 64'hA1B2C3D4E5F60718);
    run("R4 be 32", 1'b0, 1'b1, 32'd32, 64'hA1B2C3D4E5F60718);
    run("R4 be 64", 1'b0, 1'b1, 32'd64, 64'h0102030405060708);
    run("R5 w64 16", 1'b1, 1'b0, 32'd16, 64'hFFEEDDCCBBAA9988);
    run("R5 w64 32", 1'b1, 1'b0, 32'd32, 64'hFFEEDDCCBBAA9988);
    run("R5 w64 64", 1'b1, 1'b0, 32'd64, 64'h0011223344556677);
    run("R6 width 24", 1'b0, 1'b1, 32'd24, 64'hDEADBEEFCAFEF00D);
    run("R6 width 0", 1'b0, 1'b0, 32'd0, 64'h0123456789ABCDEF);
    run("R6 width 128", 1'b1, 1'b0, 32'd128, 64'h0123456789ABCDEF);
    run("R6 width 8", 1'b0, 1'b1, 32'd8, 64'h5555AAAA5555AAAA);
    run("R7 rsv 64", 1'b1, 1'b1, 32'd64, 64'h8899AABBCCDDEEFF);
    run("R7 rsv bad width", 1'b1, 1'b1, 32'd24, 64'h13579BDF02468ACE);
    run("R7 rsv 16", 1'b1, 1'b1, 32'd16, 64'h0F0E0D0C0B0A0908);
    for (int i = 0; i < 40; i++) begin
      logic [63:0] d = {$urandom, $urandom};
      logic [31:0] wd = (i % 4 == 3) ? 32'd48 : (32'd16 << (i % 3));
      run("R4 sweep", i[0], i[1], wd, d);
    end

    run("R10 setup", 1'b0, 1'b1, 32'd32, 64'h1234567890ABCDEF);
    held = {ill_le, r_le};
    @(negedge clk);
    valid = 1'b0; wide = 1'b1; order = 1'b1; width = 32'd7; op = '1;
    @(posedge clk); #1;
    check("R2 idle valid", {64'd0, v_le}, 65'd0);
    check("R10 hold", {ill_le, r_le}, held);
    @(posedge clk); #1;
    check("R10 hold 2", {ill_le, r_le}, held);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule